// File: doc/BRIEF.md
# Regulator Control Register Bank

This block is the register file that sits behind a two-wire serial slave in a power-management chip. It stores the settings of nine linear regulators: a voltage code, an enable bit and an active-discharge bit for each. It also presents one read-only register that shows the state of the charger status lines and of the over-temperature monitor. The serial engine reaches the block through a simple register bus. A write is a one-cycle strobe with an address and a byte. A read returns the byte for the presented address combinationally. The stored fields drive the regulator controls directly as ports.

The power controller loads the defaults with a one-cycle pulse, and the synchronous reset loads them as well. The start-up voltage codes of two digital regulators come from strap pins, and the straps are sampled only at those moments. Register 0 also holds a default-status flag. Only a defaults load sets it. Software can clear it but cannot set it, so software can tell whether the bank has returned to its defaults since it was last programmed.

Regulator index used on the vector ports: 0 RX, 1 TX, 2 PLL, 3 TCXO, 4 CAM, 5 ANA, 6 CORE, 7 PAD, 8 MOT.

Top module: `pmic_regbank`

## Requirements
- R1: When rst_n is low or load_defaults is high at a clock edge, every field takes its default after that edge. The defaults are: enables on for CORE, PAD, ANA and TCXO and off for the rest (ldo_en = 0x0E8); every discharge bit 1 (ldo_dischg = 0x1FF); CAM code 9; MOT code 1; ANA code 1; TCXO, RX, TX and PLL codes 6; default-status flag 1.
- R2: At a defaults load, the CORE code becomes 0 when strap_core_hi is low and 9 when it is high. The PAD code becomes 9 when strap_pad_hi is low and 25 when it is high. At any other time the straps have no effect on any register.
- R3: Bit 7 of register 0 is the default-status flag. A write to register 0 with bit 7 = 0 clears it. A write with bit 7 = 1 leaves it unchanged. Only a defaults load sets it.
- R4: Register 0 holds the PAD code in bits 4:0, and bits 6:5 read 0. Register 1 holds the CORE code in bits 4:0, and bits 7:5 read 0. Register 2 holds the MOT enable in bit 7, the MOT discharge in bit 6 and the MOT code in bits 4:0, and bit 5 reads 0.
- R5: Register 3 holds the ANA code in bits 7:5 and the CAM code in bits 4:0. Register 4 holds RX in bits 6:4 and TCXO in bits 2:0. Register 5 holds TX in bits 6:4 and PLL in bits 2:0. Bits 7 and 3 of registers 4 and 5 read 0.
- R6: Register 6 holds the enables and register 7 holds the discharge bits. Both use the order PAD, CORE, ANA, CAM, TCXO, PLL, TX, RX from bit 7 down to bit 0, so bit n drives index n of ldo_en or ldo_dischg.
- R7: A write changes only the fields of the addressed register. Changing enables leaves every code and discharge bit as it was. Every written field appears on its port and in read data after the clock edge at which bus_wr is sampled high.
- R8: Register 8 reads {4'b0, chg_busy_n, chg_fault_n, temp_ok, chg_src_n} from bit 7 down. Each input passes through a two-flop synchronizer, so a change is visible after the second rising edge.
- R9: Writes to register 8 and to addresses 9 to 15 change no register. Addresses 9 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads defaults |
| load_defaults | input | 1 | One-cycle pulse from the power controller that loads defaults |
| strap_core_hi | input | 1 | Strap selecting the CORE start-up code |
| strap_pad_hi | input | 1 | Strap selecting the PAD start-up code |
| chg_src_n | input | 1 | Charger source present, active low, asynchronous |
| temp_ok | input | 1 | Over-temperature flag, 1 = temperature normal |
| chg_fault_n | input | 1 | Charger fault, active low, asynchronous |
| chg_busy_n | input | 1 | Charging in progress, active low, asynchronous |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| ldo_en | output | 9 | Regulator enables, by regulator index |
| ldo_dischg | output | 9 | Active-discharge controls, by regulator index |
| code_pad | output | 5 | PAD voltage code |
| code_core | output | 5 | CORE voltage code |
| code_cam | output | 5 | CAM voltage code |
| code_mot | output | 5 | MOT voltage code |
| code_ana | output | 3 | ANA voltage code |
| code_tcxo | output | 3 | TCXO voltage code |
| code_rx | output | 3 | RX voltage code |
| code_tx | output | 3 | TX voltage code |
| code_pll | output | 3 | PLL voltage code |

## Verification
The bench loads defaults under all four strap combinations and then flips the straps. This shows that the straps are sampled only at a defaults load and not level-sensitive afterwards. Every byte value is written to each mixed register, and each field is checked on its port and in read data. That separates bit-position mistakes, leaks between adjacent fields and unused bits that fail to read 0. The flag is driven through every sequence of set, hold and clear, which separates "a write of 1 leaves it" from "a write of 1 sets it". All sixteen status patterns are stepped through, and each is sampled one edge and two edges after the change, which pins the synchronizer depth exactly.

// File: rtl/pmic_regbank_pkg.sv
package pmic_regbank_pkg;
  localparam int RB_DATA_W     = 8;
  localparam int RB_ADDR_W     = 4;
  localparam int RB_NUM_REGS   = 9;
  localparam int RB_NUM_LDO    = 9;
  localparam int WIDE_CODE_W   = 5;
  localparam int NARROW_CODE_W = 3;
  localparam int STAT_W        = 4;

  typedef logic [WIDE_CODE_W-1:0]   wide_code_t;
  typedef logic [NARROW_CODE_W-1:0] narrow_code_t;
  typedef logic [RB_ADDR_W-1:0]     rb_addr_t;
  typedef logic [RB_DATA_W-1:0]     rb_byte_t;

  // regulator index on the vector ports
  localparam int LDO_RX   = 0;
  localparam int LDO_TX   = 1;
  localparam int LDO_PLL  = 2;
  localparam int LDO_TCXO = 3;
  localparam int LDO_CAM  = 4;
  localparam int LDO_ANA  = 5;
  localparam int LDO_CORE = 6;
  localparam int LDO_PAD  = 7;
  localparam int LDO_MOT  = 8;

  // register addresses
  localparam rb_addr_t RA_PAD    = 4'd0;
  localparam rb_addr_t RA_CORE   = 4'd1;
  localparam rb_addr_t RA_MOT    = 4'd2;
  localparam rb_addr_t RA_ANACAM = 4'd3;
  localparam rb_addr_t RA_TCXORX = 4'd4;
  localparam rb_addr_t RA_PLLTX  = 4'd5;
  localparam rb_addr_t RA_ENABLE = 4'd6;
  localparam rb_addr_t RA_DISCHG = 4'd7;
  localparam rb_addr_t RA_STATUS = 4'd8;

  localparam wide_code_t   CAM_DFLT = 5'd9;
  localparam wide_code_t   MOT_DFLT = 5'd1;
  localparam narrow_code_t ANA_DFLT = 3'd1;
  localparam narrow_code_t RF_DFLT  = 3'd6;

  localparam logic [RB_NUM_LDO-1:0] EN_DFLT  = 9'b0_1110_1000;
  localparam logic [RB_NUM_LDO-1:0] DIS_DFLT = '1;

  // wide code steps 50 mV from 1350 mV
  function automatic wide_code_t wide_code_of_mv(input int mv);
    return wide_code_t'((mv - 1350) / 50);
  endfunction

  function automatic wide_code_t core_dflt_code(input logic strap_hi);
    return strap_hi ? wide_code_of_mv(1800) : wide_code_of_mv(1350);
  endfunction

  function automatic wide_code_t pad_dflt_code(input logic strap_hi);
    return strap_hi ? wide_code_of_mv(2600) : wide_code_of_mv(1800);
  endfunction

  function automatic rb_byte_t pack_split(input narrow_code_t hi_code,
                                          input narrow_code_t lo_code);
    return {1'b0, hi_code, 1'b0, lo_code};
  endfunction
endpackage

// File: rtl/pmic_sync_bank.sv
module pmic_sync_bank #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/pmic_cfg_store.sv
module pmic_cfg_store
  import pmic_regbank_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_defaults,
  input  logic                      strap_core_hi,
  input  logic                      strap_pad_hi,
  input  logic [RB_NUM_REGS-2:0]    wr_stb,
  input  rb_byte_t                  wdata,
  output logic                      dflt_flag,
  output wide_code_t                code_pad,
  output wide_code_t                code_core,
  output wide_code_t                code_mot,
  output wide_code_t                code_cam,
  output narrow_code_t              code_ana,
  output narrow_code_t              code_tcxo,
  output narrow_code_t              code_rx,
  output narrow_code_t              code_tx,
  output narrow_code_t              code_pll,
  output logic [RB_NUM_LDO-1:0]     en,
  output logic [RB_NUM_LDO-1:0]     dis
);
  logic defaults_evt;
  assign defaults_evt = !rst_n || load_defaults;

  // register 0: flag can only be cleared by a write
  always_ff @(posedge clk) begin
    if (defaults_evt) begin
      dflt_flag <= 1'b1;
      code_pad  <= pad_dflt_code(strap_pad_hi);
    end else if (wr_stb[RA_PAD]) begin
      code_pad <= wdata[WIDE_CODE_W-1:0];
      if (!wdata[RB_DATA_W-1]) dflt_flag <= 1'b0;
    end
  end

  // register 1
  always_ff @(posedge clk) begin
    if (defaults_evt)         code_core <= core_dflt_code(strap_core_hi);
    else if (wr_stb[RA_CORE]) code_core <= wdata[WIDE_CODE_W-1:0];
  end

  // register 2: MOT enable, discharge, code
  always_ff @(posedge clk) begin
    if (defaults_evt) begin
      en[LDO_MOT]  <= EN_DFLT[LDO_MOT];
      dis[LDO_MOT] <= DIS_DFLT[LDO_MOT];
      code_mot     <= MOT_DFLT;
    end else if (wr_stb[RA_MOT]) begin
      en[LDO_MOT]  <= wdata[7];
      dis[LDO_MOT] <= wdata[6];
      code_mot     <= wdata[WIDE_CODE_W-1:0];
    end
  end

  // register 3
  always_ff @(posedge clk) begin
    if (defaults_evt) begin
      code_ana <= ANA_DFLT;
      code_cam <= CAM_DFLT;
    end else if (wr_stb[RA_ANACAM]) begin
      code_ana <= wdata[7:5];
      code_cam <= wdata[WIDE_CODE_W-1:0];
    end
  end

  // register 4
  always_ff @(posedge clk) begin
    if (defaults_evt) begin
      code_rx   <= RF_DFLT;
      code_tcxo <= RF_DFLT;
    end else if (wr_stb[RA_TCXORX]) begin
      code_rx   <= wdata[6:4];
      code_tcxo <= wdata[2:0];
    end
  end

  // register 5
  always_ff @(posedge clk) begin
    if (defaults_evt) begin
      code_tx  <= RF_DFLT;
      code_pll <= RF_DFLT;
    end else if (wr_stb[RA_PLLTX]) begin
      code_tx  <= wdata[6:4];
      code_pll <= wdata[2:0];
    end
  end

  // registers 6 and 7: bit n maps to regulator index n
  always_ff @(posedge clk) begin
    if (defaults_evt)           en[RB_DATA_W-1:0] <= EN_DFLT[RB_DATA_W-1:0];
    else if (wr_stb[RA_ENABLE]) en[RB_DATA_W-1:0] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (defaults_evt)           dis[RB_DATA_W-1:0] <= DIS_DFLT[RB_DATA_W-1:0];
    else if (wr_stb[RA_DISCHG]) dis[RB_DATA_W-1:0] <= wdata;
  end
endmodule

// File: rtl/pmic_read_mux.sv
module pmic_read_mux
  import pmic_regbank_pkg::*;
(
  input  rb_addr_t                 addr,
  input  logic                     dflt_flag,
  input  wide_code_t               code_pad,
  input  wide_code_t               code_core,
  input  wide_code_t               code_mot,
  input  wide_code_t               code_cam,
  input  narrow_code_t             code_ana,
  input  narrow_code_t             code_tcxo,
  input  narrow_code_t             code_rx,
  input  narrow_code_t             code_tx,
  input  narrow_code_t             code_pll,
  input  logic [RB_NUM_LDO-1:0]    en,
  input  logic [RB_NUM_LDO-1:0]    dis,
  input  logic [STAT_W-1:0]        status,
  output rb_byte_t                 rdata
);
  localparam int WIDE_PAD = RB_DATA_W - WIDE_CODE_W;

  always_comb begin
    unique case (addr)
      RA_PAD:    rdata = {dflt_flag, {(WIDE_PAD-1){1'b0}}, code_pad};
      RA_CORE:   rdata = {{WIDE_PAD{1'b0}}, code_core};
      RA_MOT:    rdata = {en[LDO_MOT], dis[LDO_MOT], 1'b0, code_mot};
      RA_ANACAM: rdata = {code_ana, code_cam};
      RA_TCXORX: rdata = pack_split(code_rx, code_tcxo);
      RA_PLLTX:  rdata = pack_split(code_tx, code_pll);
      RA_ENABLE: rdata = en[RB_DATA_W-1:0];
      RA_DISCHG: rdata = dis[RB_DATA_W-1:0];
      RA_STATUS: rdata = {{(RB_DATA_W-STAT_W){1'b0}}, status};
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/pmic_regbank.sv
module pmic_regbank
  import pmic_regbank_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_defaults,
  input  logic                       strap_core_hi,
  input  logic                       strap_pad_hi,
  input  logic                       chg_src_n,
  input  logic                       temp_ok,
  input  logic                       chg_fault_n,
  input  logic                       chg_busy_n,
  input  logic                       bus_wr,
  input  logic [RB_ADDR_W-1:0]       bus_addr,
  input  logic [RB_DATA_W-1:0]       bus_wdata,
  output logic [RB_DATA_W-1:0]       bus_rdata,
  output logic [RB_NUM_LDO-1:0]      ldo_en,
  output logic [RB_NUM_LDO-1:0]      ldo_dischg,
  output logic [WIDE_CODE_W-1:0]     code_pad,
  output logic [WIDE_CODE_W-1:0]     code_core,
  output logic [WIDE_CODE_W-1:0]     code_cam,
  output logic [WIDE_CODE_W-1:0]     code_mot,
  output logic [NARROW_CODE_W-1:0]   code_ana,
  output logic [NARROW_CODE_W-1:0]   code_tcxo,
  output logic [NARROW_CODE_W-1:0]   code_rx,
  output logic [NARROW_CODE_W-1:0]   code_tx,
  output logic [NARROW_CODE_W-1:0]   code_pll
);
  // named internal events for the checker
  logic [RB_NUM_REGS-1:0] wr_stb;
  logic                   dflt_flag;
  logic [STAT_W-1:0]      status_raw;
  logic [STAT_W-1:0]      status_sync;

  for (genvar i = 0; i < RB_NUM_REGS; i++) begin : g_dec
    if (i == int'(RA_STATUS)) begin : g_ro
      assign wr_stb[i] = 1'b0;
    end else begin : g_rw
      assign wr_stb[i] = bus_wr && (bus_addr == rb_addr_t'(i));
    end
  end

  assign status_raw = {chg_busy_n, chg_fault_n, temp_ok, chg_src_n};

  pmic_sync_bank #(
    .WIDTH  (STAT_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (status_raw),
    .dout  (status_sync)
  );

  pmic_cfg_store u_store (
    .clk           (clk),
    .rst_n         (rst_n),
    .load_defaults (load_defaults),
    .strap_core_hi (strap_core_hi),
    .strap_pad_hi  (strap_pad_hi),
    .wr_stb        (wr_stb[RB_NUM_REGS-2:0]),
    .wdata         (bus_wdata),
    .dflt_flag     (dflt_flag),
    .code_pad      (code_pad),
    .code_core     (code_core),
    .code_mot      (code_mot),
    .code_cam      (code_cam),
    .code_ana      (code_ana),
    .code_tcxo     (code_tcxo),
    .code_rx       (code_rx),
    .code_tx       (code_tx),
    .code_pll      (code_pll),
    .en            (ldo_en),
    .dis           (ldo_dischg)
  );

  pmic_read_mux u_rmux (
    .addr      (bus_addr),
    .dflt_flag (dflt_flag),
    .code_pad  (code_pad),
    .code_core (code_core),
    .code_mot  (code_mot),
    .code_cam  (code_cam),
    .code_ana  (code_ana),
    .code_tcxo (code_tcxo),
    .code_rx   (code_rx),
    .code_tx   (code_tx),
    .code_pll  (code_pll),
    .en        (ldo_en),
    .dis       (ldo_dischg),
    .status    (status_sync),
    .rdata     (bus_rdata)
  );
endmodule

// File: rtl/pmic_regbank_chk.sv
module pmic_regbank_chk
  import pmic_regbank_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   load_defaults,
  input logic                   wdata_flag_bit,
  input logic [RB_NUM_REGS-1:0] wr_stb,
  input logic                   dflt_flag,
  input logic [WIDE_CODE_W-1:0] code_core,
  input logic [WIDE_CODE_W-1:0] code_pad,
  input logic [RB_NUM_LDO-1:0]  ldo_en,
  input logic [RB_NUM_LDO-1:0]  ldo_dischg
);
  // R3
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dflt_flag) |-> $past(load_defaults));

  // R3
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb[RA_PAD] && wdata_flag_bit && !load_defaults)
      |=> (dflt_flag == $past(dflt_flag)));

  // R3
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb[RA_PAD] && !wdata_flag_bit && !load_defaults) |=> !dflt_flag);

  // R1
  dflt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_defaults |=> (ldo_en == EN_DFLT && (&ldo_dischg) && dflt_flag));

  // R7
  en_write_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb[RA_ENABLE] && !load_defaults)
      |=> ($stable(code_core) && $stable(code_pad) && $stable(ldo_dischg)
           && $stable(ldo_en[LDO_MOT])));

  // R2
  strap_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_defaults && !wr_stb[RA_CORE] && !wr_stb[RA_PAD])
      |=> ($stable(code_core) && $stable(code_pad)));

  // R9
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb) && !wr_stb[RA_STATUS]);
endmodule

bind pmic_regbank pmic_regbank_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .load_defaults  (load_defaults),
  .wdata_flag_bit (bus_wdata[7]),
  .wr_stb         (wr_stb),
  .dflt_flag      (dflt_flag),
  .code_core      (code_core),
  .code_pad       (code_pad),
  .ldo_en         (ldo_en),
  .ldo_dischg     (ldo_dischg)
);

// File: tb/pmic_regbank_test.sv
`timescale 1ns/1ps
module pmic_regbank_test;
  logic clk = 1'b0;
  logic rst_n, load_defaults, strap_core_hi, strap_pad_hi;
  logic chg_src_n, temp_ok, chg_fault_n, chg_busy_n;
  logic bus_wr;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [8:0] ldo_en, ldo_dischg;
  logic [4:0] code_pad, code_core, code_cam, code_mot;
  logic [2:0] code_ana, code_tcxo, code_rx, code_tx, code_pll;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pmic_regbank uut (
    .clk(clk), .rst_n(rst_n), .load_defaults(load_defaults),
    .strap_core_hi(strap_core_hi), .strap_pad_hi(strap_pad_hi),
    .chg_src_n(chg_src_n), .temp_ok(temp_ok), .chg_fault_n(chg_fault_n),
    .chg_busy_n(chg_busy_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ldo_en(ldo_en),
    .ldo_dischg(ldo_dischg), .code_pad(code_pad), .code_core(code_core),
    .code_cam(code_cam), .code_mot(code_mot), .code_ana(code_ana),
    .code_tcxo(code_tcxo), .code_rx(code_rx), .code_tx(code_tx),
    .code_pll(code_pll)
  );

  function automatic int mv_to_code(input int mv, input int base);
    return (mv - base) / 50;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    bus_addr = a;
    #0.5;
    check(tag, {24'd0, bus_rdata}, {24'd0, exp});
  endtask

  task automatic pulse_defaults();
    @(negedge clk); load_defaults = 1'b1;
    @(negedge clk); load_defaults = 1'b0;
  endtask

  task automatic check_all_defaults(input string tag, input logic sc, input logic sp);
    int core_c, pad_c;
    core_c = sc ? mv_to_code(1800, 1350) : mv_to_code(1350, 1350);
    pad_c  = sp ? mv_to_code(2600, 1350) : mv_to_code(1800, 1350);
    rd_chk({tag, " R1 R3 reg0"}, 4'd0, 8'h80 | 8'(pad_c));
    rd_chk({tag, " R2 reg1"}, 4'd1, 8'(core_c));
    rd_chk({tag, " R1 reg2"}, 4'd2, 8'h40 | 8'(mv_to_code(1400, 1350)));
    rd_chk({tag, " R1 reg3"}, 4'd3, {3'(mv_to_code(2600, 2550)), 5'(mv_to_code(1800, 1350))});
    rd_chk({tag, " R1 reg4"}, 4'd4, 8'h66);
    rd_chk({tag, " R1 reg5"}, 4'd5, 8'h66);
    rd_chk({tag, " R1 reg6"}, 4'd6, 8'hE8);
    rd_chk({tag, " R1 reg7"}, 4'd7, 8'hFF);
    check({tag, " R1 ldo_en"}, {23'd0, ldo_en}, 32'h0E8);
    check({tag, " R1 ldo_dischg"}, {23'd0, ldo_dischg}, 32'h1FF);
    check({tag, " R2 code_core"}, {27'd0, code_core}, 32'(core_c));
    check({tag, " R2 code_pad"}, {27'd0, code_pad}, 32'(pad_c));
  endtask

  task automatic set_status(input logic [3:0] p);
    chg_src_n = p[0]; temp_ok = p[1]; chg_fault_n = p[2]; chg_busy_n = p[3];
  endtask

  initial begin
    logic [7:0] snap [8];
    rst_n = 1'b0; load_defaults = 1'b0; strap_core_hi = 1'b0; strap_pad_hi = 1'b0;
    set_status(4'hF);
    bus_wr = 1'b0; bus_addr = 4'd0; bus_wdata = 8'd0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all_defaults("reset", 1'b0, 1'b0);

    // R2: strap sweep, then straps ignored afterwards
    for (int s = 0; s < 4; s++) begin
      strap_core_hi = s[0]; strap_pad_hi = s[1];
      pulse_defaults();
      check_all_defaults("strap", s[0], s[1]);
      strap_core_hi = ~s[0]; strap_pad_hi = ~s[1];
      repeat (3) @(negedge clk);
      rd_chk("R2 strap ignored reg0", 4'd0, 8'h80 | (s[1] ? 8'd25 : 8'd9));
      rd_chk("R2 strap ignored reg1", 4'd1, s[0] ? 8'd9 : 8'd0);
    end

    // R1: defaults restore after edits
    strap_core_hi = 1'b0; strap_pad_hi = 1'b1;
    wr(4'd6, 8'h17); wr(4'd7, 8'h00); wr(4'd2, 8'hDF); wr(4'd3, 8'hFF);
    wr(4'd0, 8'h02); wr(4'd1, 8'h1F);
    pulse_defaults();
    check_all_defaults("restore", 1'b0, 1'b1);

    // R3: flag behaviour
    wr(4'd0, 8'h94);
    rd_chk("R3 write1 keeps flag", 4'd0, 8'h94);
    wr(4'd0, 8'h03);
    rd_chk("R3 write0 clears flag", 4'd0, 8'h03);
    wr(4'd0, 8'hFF);
    rd_chk("R3 write1 does not set, R4 bits6:5 zero", 4'd0, 8'h1F);
    pulse_defaults();
    rd_chk("R3 defaults set flag", 4'd0, 8'h80 | 8'd25);
    wr(4'd0, 8'h00);

    // R4: wide codes
    for (int c = 0; c < 32; c++) begin
      wr(4'd1, {3'b111, 5'(c)});
      rd_chk("R4 reg1", 4'd1, 8'(c));
      check("R4 code_core", {27'd0, code_core}, 32'(c));
      wr(4'd0, {1'b0, 2'b11, 5'(c)});
      rd_chk("R4 reg0", 4'd0, 8'(c));
      check("R4 code_pad", {27'd0, code_pad}, 32'(c));
    end
    for (int d = 0; d < 256; d++) begin
      wr(4'd2, 8'(d));
      rd_chk("R4 reg2", 4'd2, 8'(d) & 8'hDF);
      check("R4 mot en/dis/code", {22'd0, ldo_en[8], ldo_dischg[8], code_mot},
            {22'd0, 1'(d >> 7), 1'(d >> 6), 5'(d)});
    end

    // R5: split registers
    for (int d = 0; d < 256; d++) begin
      wr(4'd3, 8'(d)); wr(4'd4, 8'(d)); wr(4'd5, 8'(d));
      rd_chk("R5 reg3", 4'd3, 8'(d));
      rd_chk("R5 reg4", 4'd4, 8'(d) & 8'h77);
      rd_chk("R5 reg5", 4'd5, 8'(d) & 8'h77);
      check("R5 fields", {14'd0, code_ana, code_cam, code_rx, code_tcxo, code_tx, code_pll},
            {14'd0, 3'(d >> 5), 5'(d), 3'(d >> 4), 3'(d), 3'(d >> 4), 3'(d)});
    end

    // R6 R7: enable and discharge registers, isolation
    wr(4'd1, 8'h0A); wr(4'd0, 8'h0B); wr(4'd7, 8'h5A); wr(4'd2, 8'h41);
    for (int d = 0; d < 256; d++) begin
      wr(4'd6, 8'(d));
      rd_chk("R6 reg6", 4'd6, 8'(d));
      check("R6 ldo_en", {23'd0, ldo_en}, {23'd0, 1'b0, 8'(d)});
      check("R7 en write keeps rest", {14'd0, code_core, code_pad, ldo_dischg},
            {14'd0, 5'd10, 5'd11, 9'h15A});
    end
    for (int d = 0; d < 256; d++) begin
      wr(4'd7, 8'(d));
      rd_chk("R6 reg7", 4'd7, 8'(d));
      check("R6 ldo_dischg", {23'd0, ldo_dischg}, {23'd0, 1'b1, 8'(d)});
      check("R7 dis write keeps en", {23'd0, ldo_en}, 32'h0FF);
    end

    // R8: status sync, latency two edges
    @(negedge clk); set_status(4'h0);
    repeat (3) @(negedge clk);
    for (int p = 0; p < 16; p++) begin
      @(negedge clk);
      set_status(4'(p));
      @(negedge clk);
      rd_chk("R8 one edge old", 4'd8, (p == 0) ? 8'h00 : 8'(p - 1));
      @(negedge clk);
      rd_chk("R8 two edges new", 4'd8, 8'(p));
    end

    // R9: ignored writes
    set_status(4'h5);
    repeat (3) @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      bus_addr = 4'(a); #0.5; snap[a] = bus_rdata;
    end
    for (int a = 8; a < 16; a++) wr(4'(a), 8'hFF);
    for (int a = 0; a < 8; a++) rd_chk("R9 regs unchanged", 4'(a), snap[a]);
    rd_chk("R9 reg8 write ignored", 4'd8, 8'h05);
    for (int a = 9; a < 16; a++) rd_chk("R9 unmapped reads 0", 4'(a), 8'h00);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule